// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block turns one AUX request into the exact byte stream a transaction sequencer must put on the wire, and turns the bytes that come back into a reply code, a byte count and a payload. A request is a 4-bit command, a 20-bit target address, a payload size and, for writes, up to sixteen payload bytes. The framer builds the four-byte header, appends the write payload, and decides how many bytes go out and how many bytes the sequencer should wait for. A native write to the key-transfer address raises a select flag so that the transmitter inserts the key material right after the header.

Unsupported commands and frames that would not fit the 20-byte data window are refused at once, and the sequencer is never started for them. For an accepted request the framer pulses a start strobe and holds the frame, the lengths and the flag steady until the sequencer reports completion. It then decodes the returned bytes. A write reply yields either the full payload size or a short-write count clamped to that size. A read reply yields the bytes that follow the reply-code byte.

Top module: `aux_req_framer`

## Requirements
- R1: The outgoing frame carries byte 0 = {command[3:0], address[19:16]}, byte 1 = address[15:8], byte 2 = address[7:0], byte 3 = size minus one (modulo 256), then for writes the payload bytes in order from byte 4. Byte i of a frame sits at bits [8i+7:8i], and every byte at an index at or beyond the send length is zero.
- R2: Commands 0x8 (native write), 0x0 (two-wire write) and 0x2 (two-wire write with status update) are writes. A write's send length is 4 plus the size when the size is nonzero, and 3 when the size is zero. Its expected reply length is 2.
- R3: Commands 0x9 (native read) and 0x1 (two-wire read) are reads. A read's send length is 4 when the size is nonzero and 3 when it is zero. Its expected reply length is the size plus one.
- R4: Bit 2 of the command (continuation bit) is cleared before the command is classified. Any other masked value gives status 1 (bad request) with reply, count and data zero.
- R5: A write with a send length above 20, or a read with an expected reply length above 20, gives status 2 (too big) with reply, count and data zero.
- R6: The key-select output is 1 exactly when the masked command is 0x8 and the address is 0x68007.
- R7: For a response with status 0, the reply code is bits 7:4 of received byte 0.
- R8: For a write, the received length is first limited to the expected length. With two bytes the count is byte 1 clamped to the payload size. With one byte the count is the payload size. With none the status is 3 (empty reply) and reply, count and data are zero. A write response's data is zero.
- R9: For a read, with the received length limited to the expected length as n, the count is n-1 and data byte j is received byte j+1 for j < n-1 and zero beyond. When n = 0 the status is 3 and count and data are zero.
- R10: A request is taken only while busy is 0. An accepted request raises busy and pulses seq_start for one cycle at the next edge. Frame, lengths and key-select then stay fixed until seq_done is sampled. rsp_valid pulses for one cycle one edge after seq_done, or one edge after the request for a refused one. A req_valid seen while busy has no effect.
- R11: After reset, busy, seq_start, rsp_valid and key_sel are 0, and tx_len and rx_expect are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 4 | Request command code |
| req_addr | input | 20 | Target address |
| req_size | input | 5 | Payload size in bytes |
| req_payload | input | 128 | Write payload, byte i at bits [8i+7:8i] |
| busy | output | 1 | Request in flight with the sequencer |
| seq_start | output | 1 | One-cycle launch strobe to the sequencer |
| tx_frame | output | 160 | Bytes to send, byte i at bits [8i+7:8i] |
| tx_len | output | 5 | Number of bytes to send |
| rx_expect | output | 5 | Number of reply bytes expected |
| key_sel | output | 1 | Insert key material after the header |
| seq_done | input | 1 | Sequencer finished; received bytes valid |
| rx_frame | input | 160 | Received bytes, byte i at bits [8i+7:8i] |
| rx_len | input | 5 | Number of bytes received |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 bad request, 2 too big, 3 empty reply |
| rsp_reply | output | 4 | Reply code |
| rsp_count | output | 5 | Bytes written (write) or returned (read) |
| rsp_data | output | 152 | Read payload, byte j at bits [8j+7:8j] |

## Verification
The bench goes after the length edges: a 16-byte write that exactly fills the window next to a 17-byte write that must be refused, and a 19-byte read next to a 20-byte read. A design with an off-by-one bound would either refuse a legal request or launch an oversize one. It sends zero-size reads and writes, where a design that forgot the address-only form would send a fourth header byte. It sends replies longer than expected, short-write counts above the payload size and empty replies, where a missing clamp would report phantom bytes or stale data. It sets the continuation bit on every command class and on the key address, and raises req_valid while busy, where a design that did not mask the bit or did not ignore the request would misclassify it or corrupt the held frame.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_BADREQ  = 2'd1,
        ST_TOOBIG  = 2'd2,
        ST_NOREPLY = 2'd3
    } aux_status_e;

    localparam logic [3:0] CMD_I2C_WR  = 4'h0;
    localparam logic [3:0] CMD_I2C_RD  = 4'h1;
    localparam logic [3:0] CMD_I2C_WSU = 4'h2;
    localparam logic [3:0] CMD_NAT_WR  = 4'h8;
    localparam logic [3:0] CMD_NAT_RD  = 4'h9;
    localparam logic [3:0] CMD_CONT    = 4'h4;

    localparam logic [19:0] KEY_ADDR   = 20'h68007;

    localparam int HDR_BYTES  = 4;
    localparam int BARE_BYTES = 3;

endpackage

// File: rtl/aux_req_classify.sv
module aux_req_classify
    import aux_frm_pkg::*;
#(
    parameter int MAX_FRAME = 20,
    parameter int SIZE_W    = 5,
    parameter int LEN_W     = 5
) (
    input  logic [3:0]        cmd,
    input  logic [19:0]       addr,
    input  logic [SIZE_W-1:0] size,
    output aux_status_e       status,
    output logic              is_write,
    output logic [LEN_W-1:0]  tx_len,
    output logic [LEN_W-1:0]  rx_expect,
    output logic              key_sel
);
    localparam int CW = ((SIZE_W > LEN_W) ? SIZE_W : LEN_W) + 2;
    localparam logic [CW-1:0] MAXF_C = CW'(MAX_FRAME);
    localparam logic [CW-1:0] HDR_C  = CW'(HDR_BYTES);
    localparam logic [CW-1:0] BARE_C = CW'(BARE_BYTES);
    localparam logic [CW-1:0] ONE_C  = CW'(1);
    localparam logic [CW-1:0] TWO_C  = CW'(2);

    logic [3:0]    kind;
    logic          wr_kind;
    logic          rd_kind;
    logic [CW-1:0] sz_ext;
    logic [CW-1:0] snd_len;
    logic [CW-1:0] exp_len;
    logic          oversize;

    always_comb begin
        kind    = cmd & ~CMD_CONT;
        wr_kind = (kind == CMD_NAT_WR) || (kind == CMD_I2C_WR) || (kind == CMD_I2C_WSU);
        rd_kind = (kind == CMD_NAT_RD) || (kind == CMD_I2C_RD);
        sz_ext  = CW'(size);

        if (size == '0) begin
            snd_len = BARE_C;
        end else if (wr_kind) begin
            snd_len = HDR_C + sz_ext;
        end else begin
            snd_len = HDR_C;
        end

        exp_len  = wr_kind ? TWO_C : (sz_ext + ONE_C);
        oversize = (wr_kind && (snd_len > MAXF_C)) || (rd_kind && (exp_len > MAXF_C));

        if (!wr_kind && !rd_kind) begin
            status = ST_BADREQ;
        end else if (oversize) begin
            status = ST_TOOBIG;
        end else begin
            status = ST_OK;
        end

        is_write  = wr_kind;
        tx_len    = LEN_W'(snd_len);
        rx_expect = LEN_W'(exp_len);
        key_sel   = (kind == CMD_NAT_WR) && (addr == KEY_ADDR);
    end

endmodule

// File: rtl/aux_frame_build.sv
module aux_frame_build
    import aux_frm_pkg::*;
#(
    parameter int MAX_FRAME = 20,
    parameter int SIZE_W    = 5,
    parameter int LEN_W     = 5
) (
    input  logic [3:0]                         cmd,
    input  logic [19:0]                        addr,
    input  logic [SIZE_W-1:0]                  size,
    input  logic [LEN_W-1:0]                   tx_len,
    input  logic [(MAX_FRAME-HDR_BYTES)*8-1:0] payload,
    output logic [MAX_FRAME*8-1:0]             frame
);
    logic [7:0] size_m1;

    always_comb begin
        size_m1 = 8'(size) - 8'd1;
    end

    for (genvar i = 0; i < MAX_FRAME; i++) begin : g_byte
        logic [7:0] raw;
        always_comb begin
            if (i == 0) begin
                raw = {cmd, addr[19:16]};
            end else if (i == 1) begin
                raw = addr[15:8];
            end else if (i == 2) begin
                raw = addr[7:0];
            end else if (i == 3) begin
                raw = size_m1;
            end else begin
                raw = payload[((i >= HDR_BYTES) ? (i - HDR_BYTES) : 0)*8 +: 8];
            end
            frame[i*8 +: 8] = (LEN_W'(i) < tx_len) ? raw : 8'h00;
        end
    end

endmodule

// File: rtl/aux_reply_parse.sv
module aux_reply_parse
    import aux_frm_pkg::*;
#(
    parameter int MAX_FRAME = 20,
    parameter int SIZE_W    = 5,
    parameter int LEN_W     = 5
) (
    input  logic [MAX_FRAME*8-1:0]     rx_frame,
    input  logic [LEN_W-1:0]           rx_len,
    input  logic [LEN_W-1:0]           rx_expect,
    input  logic                       is_write,
    input  logic [SIZE_W-1:0]          size,
    output aux_status_e                status,
    output logic [3:0]                 reply,
    output logic [LEN_W-1:0]           count,
    output logic [(MAX_FRAME-1)*8-1:0] data
);
    logic [LEN_W-1:0] eff;
    logic [7:0]       wr_cnt;
    logic [7:0]       size8;

    always_comb begin
        eff   = (rx_len > rx_expect) ? rx_expect : rx_len;
        size8 = 8'(size);

        if (eff >= LEN_W'(2)) begin
            wr_cnt = (rx_frame[15:8] > size8) ? size8 : rx_frame[15:8];
        end else begin
            wr_cnt = size8;
        end

        if (eff == '0) begin
            status = ST_NOREPLY;
            reply  = 4'h0;
            count  = '0;
        end else begin
            status = ST_OK;
            reply  = rx_frame[7:4];
            count  = is_write ? LEN_W'(wr_cnt) : (eff - LEN_W'(1));
        end
    end

    for (genvar j = 0; j < MAX_FRAME-1; j++) begin : g_out
        always_comb begin
            if (!is_write && (LEN_W'(j + 1) < eff)) begin
                data[j*8 +: 8] = rx_frame[(j+1)*8 +: 8];
            end else begin
                data[j*8 +: 8] = 8'h00;
            end
        end
    end

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
    import aux_frm_pkg::*;
#(
    parameter int MAX_FRAME = 20,
    parameter int SIZE_W    = 5,
    localparam int LEN_W    = $clog2(MAX_FRAME + 1),
    localparam int PAY_W    = (MAX_FRAME - HDR_BYTES) * 8,
    localparam int FRM_W    = MAX_FRAME * 8,
    localparam int DAT_W    = (MAX_FRAME - 1) * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_cmd,
    input  logic [19:0]       req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [PAY_W-1:0]  req_payload,
    output logic              busy,
    output logic              seq_start,
    output logic [FRM_W-1:0]  tx_frame,
    output logic [LEN_W-1:0]  tx_len,
    output logic [LEN_W-1:0]  rx_expect,
    output logic              key_sel,
    input  logic              seq_done,
    input  logic [FRM_W-1:0]  rx_frame,
    input  logic [LEN_W-1:0]  rx_len,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [3:0]        rsp_reply,
    output logic [LEN_W-1:0]  rsp_count,
    output logic [DAT_W-1:0]  rsp_data
);

    typedef struct packed {
        logic              busy;
        logic              start;
        logic              rsp_valid;
        aux_status_e       status;
        logic [3:0]        reply;
        logic [LEN_W-1:0]  count;
        logic [DAT_W-1:0]  data;
        logic [FRM_W-1:0]  frame;
        logic [LEN_W-1:0]  tx_len;
        logic [LEN_W-1:0]  rx_expect;
        logic              key;
        logic              is_write;
        logic [SIZE_W-1:0] size;
    } ctl_t;

    ctl_t st_d, st_q;

    aux_status_e      cls_status;
    logic             cls_write;
    logic [LEN_W-1:0] cls_tx_len;
    logic [LEN_W-1:0] cls_rx_exp;
    logic             cls_key;
    logic [FRM_W-1:0] bld_frame;
    aux_status_e      prs_status;
    logic [3:0]       prs_reply;
    logic [LEN_W-1:0] prs_count;
    logic [DAT_W-1:0] prs_data;

    aux_req_classify #(
        .MAX_FRAME (MAX_FRAME),
        .SIZE_W    (SIZE_W),
        .LEN_W     (LEN_W)
    ) u_classify (
        .cmd       (req_cmd),
        .addr      (req_addr),
        .size      (req_size),
        .status    (cls_status),
        .is_write  (cls_write),
        .tx_len    (cls_tx_len),
        .rx_expect (cls_rx_exp),
        .key_sel   (cls_key)
    );

    aux_frame_build #(
        .MAX_FRAME (MAX_FRAME),
        .SIZE_W    (SIZE_W),
        .LEN_W     (LEN_W)
    ) u_build (
        .cmd     (req_cmd),
        .addr    (req_addr),
        .size    (req_size),
        .tx_len  (cls_tx_len),
        .payload (req_payload),
        .frame   (bld_frame)
    );

    aux_reply_parse #(
        .MAX_FRAME (MAX_FRAME),
        .SIZE_W    (SIZE_W),
        .LEN_W     (LEN_W)
    ) u_parse (
        .rx_frame  (rx_frame),
        .rx_len    (rx_len),
        .rx_expect (st_q.rx_expect),
        .is_write  (st_q.is_write),
        .size      (st_q.size),
        .status    (prs_status),
        .reply     (prs_reply),
        .count     (prs_count),
        .data      (prs_data)
    );

    always_comb begin
        st_d           = st_q;
        st_d.start     = 1'b0;
        st_d.rsp_valid = 1'b0;

        if (!st_q.busy) begin
            if (req_valid) begin
                if (cls_status != ST_OK) begin
                    st_d.rsp_valid = 1'b1;
                    st_d.status    = cls_status;
                    st_d.reply     = 4'h0;
                    st_d.count     = '0;
                    st_d.data      = '0;
                end else begin
                    st_d.busy      = 1'b1;
                    st_d.start     = 1'b1;
                    st_d.frame     = bld_frame;
                    st_d.tx_len    = cls_tx_len;
                    st_d.rx_expect = cls_rx_exp;
                    st_d.key       = cls_key;
                    st_d.is_write  = cls_write;
                    st_d.size      = req_size;
                end
            end
        end else if (seq_done) begin
            st_d.busy      = 1'b0;
            st_d.rsp_valid = 1'b1;
            st_d.status    = prs_status;
            st_d.reply     = prs_reply;
            st_d.count     = prs_count;
            st_d.data      = prs_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign seq_start  = st_q.start;
    assign tx_frame   = st_q.frame;
    assign tx_len     = st_q.tx_len;
    assign rx_expect  = st_q.rx_expect;
    assign key_sel    = st_q.key;
    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_status = st_q.status;
    assign rsp_reply  = st_q.reply;
    assign rsp_count  = st_q.count;
    assign rsp_data   = st_q.data;

    // R10
    start_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> busy);

    // R10
    held_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(tx_frame) && $stable(tx_len)
                                   && $stable(rx_expect) && $stable(key_sel)));

    // R10
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4
    reject_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status == ST_BADREQ || rsp_status == ST_TOOBIG)) |-> !$past(busy));

    // R6
    key_frame_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && key_sel) |-> (((tx_frame[7:4] & 4'hB) == 4'h8) && (tx_frame[3:0] == 4'h6)
                               && (tx_frame[15:8] == 8'h80) && (tx_frame[23:16] == 8'h07)));

    // R2
    send_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((tx_len >= LEN_W'(BARE_BYTES)) && (tx_len <= LEN_W'(MAX_FRAME))));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_count < LEN_W'(MAX_FRAME)));

endmodule

// File: tb/tb_aux_req_framer.sv
module tb_aux_req_framer;
    localparam int CLK_PERIOD = 10;
    localparam int MAXF  = 20;
    localparam int MAXWR = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [3:0]   req_cmd = 4'h0;
    logic [19:0]  req_addr = 20'h0;
    logic [4:0]   req_size = 5'd0;
    logic [127:0] req_payload;
    logic         busy, seq_start, key_sel, rsp_valid;
    logic [159:0] tx_frame;
    logic [4:0]   tx_len, rx_expect, rsp_count;
    logic         seq_done = 1'b0;
    logic [159:0] rx_frame;
    logic [4:0]   rx_len = 5'd0;
    logic [1:0]   rsp_status;
    logic [3:0]   rsp_reply;
    logic [151:0] rsp_data;

    logic [7:0] pay [MAXWR];
    logic [7:0] rxb [MAXF];

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < MAXWR; i++) req_payload[i*8 +: 8] = pay[i];
        for (int i = 0; i < MAXF; i++) rx_frame[i*8 +: 8] = rxb[i];
    end

    aux_req_framer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_size(req_size), .req_payload(req_payload),
        .busy(busy), .seq_start(seq_start), .tx_frame(tx_frame), .tx_len(tx_len),
        .rx_expect(rx_expect), .key_sel(key_sel), .seq_done(seq_done),
        .rx_frame(rx_frame), .rx_len(rx_len), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_reply(rsp_reply), .rsp_count(rsp_count),
        .rsp_data(rsp_data)
    );

    // behavioural reference model
    int m_busy, m_start, m_rv, m_status, m_reply, m_count;
    int m_txlen, m_rxexp, m_key, m_wr, m_size;
    logic [159:0] m_frame;
    logic [151:0] m_data;

    task automatic model_accept();
        int k, sz, txl, rxe;
        bit wr, rd;
        logic [7:0] b [MAXF];
        k  = int'(req_cmd) & 11;
        sz = int'(req_size);
        wr = (k == 8) || (k == 0) || (k == 2);
        rd = (k == 9) || (k == 1);
        if (!wr && !rd) begin
            m_rv = 1; m_status = 1; m_reply = 0; m_count = 0; m_data = '0;
            return;
        end
        if (sz == 0) txl = 3; else if (wr) txl = 4 + sz; else txl = 4;
        rxe = wr ? 2 : sz + 1;
        if ((wr && txl > MAXF) || (rd && rxe > MAXF)) begin
            m_rv = 1; m_status = 2; m_reply = 0; m_count = 0; m_data = '0;
            return;
        end
        for (int i = 0; i < MAXF; i++) b[i] = 8'h00;
        b[0] = {req_cmd, req_addr[19:16]};
        b[1] = req_addr[15:8];
        b[2] = req_addr[7:0];
        b[3] = 8'((sz + 255) % 256);
        if (wr) for (int i = 0; i < sz; i++) b[4+i] = pay[i];
        for (int i = 0; i < MAXF; i++) m_frame[i*8 +: 8] = (i < txl) ? b[i] : 8'h00;
        m_busy = 1; m_start = 1;
        m_txlen = txl; m_rxexp = rxe; m_wr = wr; m_size = sz;
        m_key = (k == 8) && (req_addr == 20'h68007);
    endtask

    task automatic model_reply();
        int n;
        n = int'(rx_len);
        if (n > m_rxexp) n = m_rxexp;
        m_busy = 0; m_rv = 1; m_data = '0;
        if (n == 0) begin
            m_status = 3; m_reply = 0; m_count = 0;
        end else begin
            m_status = 0;
            m_reply = int'(rxb[0]) / 16;
            if (m_wr) begin
                if (n >= 2) m_count = (int'(rxb[1]) > m_size) ? m_size : int'(rxb[1]);
                else m_count = m_size;
            end else begin
                m_count = n - 1;
                for (int j = 0; j < MAXF-1; j++)
                    m_data[j*8 +: 8] = (j < n - 1) ? rxb[j+1] : 8'h00;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_start = 0; m_rv = 0; m_status = 0; m_reply = 0; m_count = 0;
            m_txlen = 0; m_rxexp = 0; m_key = 0; m_wr = 0; m_size = 0;
            m_frame = '0; m_data = '0;
        end else if (m_busy == 0) begin
            m_start = 0; m_rv = 0;
            if (req_valid) model_accept();
        end else begin
            m_start = 0; m_rv = 0;
            if (seq_done) model_reply();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_vec(input bit ok, input string tag, input string what,
                           input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every clock, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (cmp_on && !finished) begin
            string lt, pt;
            lt = m_wr ? "R2" : "R3";
            chk(busy == m_busy, "R10", "busy", busy, m_busy);
            chk(seq_start == m_start, "R10", "seq_start", seq_start, m_start);
            chk(rsp_valid == m_rv, "R10", "rsp_valid", rsp_valid, m_rv);
            chk(int'(tx_len) == m_txlen, lt, "tx_len", tx_len, m_txlen);
            chk(int'(rx_expect) == m_rxexp, lt, "rx_expect", rx_expect, m_rxexp);
            chk(key_sel == m_key, "R6", "key_sel", key_sel, m_key);
            chk_vec(tx_frame === m_frame, "R1", "tx_frame", tx_frame, m_frame);
            if (m_rv) begin
                if (m_status == 1) pt = "R4";
                else if (m_status == 2) pt = "R5";
                else if (m_wr) pt = "R8";
                else pt = "R9";
                chk(int'(rsp_status) == m_status, pt, "rsp_status", rsp_status, m_status);
                chk(int'(rsp_reply) == m_reply, "R7", "rsp_reply", rsp_reply, m_reply);
                chk(int'(rsp_count) == m_count, pt, "rsp_count", rsp_count, m_count);
                chk_vec({8'h00, rsp_data} === {8'h00, m_data}, pt, "rsp_data",
                        {8'h00, rsp_data}, {8'h00, m_data});
            end
        end
    end

    task automatic clear_rx();
        for (int i = 0; i < MAXF; i++) rxb[i] = 8'h00;
    endtask

    task automatic send(input logic [3:0] c, input logic [19:0] a, input int sz);
        @(negedge clk);
        req_cmd = c; req_addr = a; req_size = 5'(sz); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_seq(input int delay, input int n);
        repeat (delay) @(negedge clk);
        rx_len = 5'(n); seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic refuse_case(input logic [3:0] c, input int sz);
        send(c, 20'h00321, sz);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        for (int i = 0; i < MAXWR; i++) pay[i] = 8'(8'h30 + i);
        clear_rx();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
        chk(seq_start == 1'b0, "R11", "seq_start after reset", seq_start, 0);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", rsp_valid, 0);
        chk(key_sel == 1'b0, "R11", "key_sel after reset", key_sel, 0);
        chk(tx_len == 5'd0 && rx_expect == 5'd0, "R11", "lengths after reset", tx_len, 0);
        cmp_on = 1;

        // R1 R2 R8: native write, short-write count inside range
        pay[0] = 8'hAA; pay[1] = 8'hBB; pay[2] = 8'hCC;
        clear_rx(); rxb[0] = 8'h00; rxb[1] = 8'h02;
        send(4'h8, 20'h12345, 3); finish_seq(3, 2);
        // R4 R2: continuation bit on a native write, zero size (address only)
        clear_rx(); send(4'hC, 20'h00100, 0); finish_seq(1, 1);
        // R6: key address on native write, one-byte reply gives full size
        send(4'h8, 20'h68007, 5); finish_seq(2, 1);
        // R6: key address with continuation bit still native write
        send(4'hC, 20'h68007, 1); finish_seq(0, 1);
        // R6 R8 R7: two-wire write to key address, count clamped to size
        clear_rx(); rxb[0] = 8'h10; rxb[1] = 8'hFF;
        send(4'h0, 20'h68007, 2); finish_seq(2, 2);
        // R2 R8: 16-byte status-update write, reply longer than expected truncated
        clear_rx(); rxb[0] = 8'h00; rxb[1] = 8'h05; rxb[2] = 8'h77;
        send(4'h6, 20'hFEDCB, 16); finish_seq(4, 3);
        // R5: 17-byte write refused
        refuse_case(4'h8, 17);
        refuse_case(4'h2, 31);
        // R3 R9: native read of 4 bytes
        clear_rx(); rxb[0] = 8'h00; rxb[1] = 8'h11; rxb[2] = 8'h22; rxb[3] = 8'h33; rxb[4] = 8'h44;
        send(4'h9, 20'hABCDE, 4); finish_seq(3, 5);
        // R3 R9: zero-size two-wire read with continuation bit
        clear_rx(); rxb[0] = 8'h00;
        send(4'h5, 20'h00050, 0); finish_seq(1, 1);
        // R3 R9: 19-byte read fills window
        clear_rx(); for (int i = 0; i < MAXF; i++) rxb[i] = 8'(8'h80 + i);
        rxb[0] = 8'h00;
        send(4'h1, 20'h00A50, 19); finish_seq(2, 20);
        // R5: 20-byte read refused
        refuse_case(4'h9, 20);
        // R9 R7: reply longer than expected, extra bytes dropped, reply code 2
        clear_rx(); rxb[0] = 8'h20; rxb[1] = 8'h5A; rxb[2] = 8'hA5; rxb[3] = 8'hEE; rxb[4] = 8'hDD;
        send(4'h9, 20'h00200, 2); finish_seq(1, 7);
        // R4: unsupported codes
        refuse_case(4'h3, 2);
        refuse_case(4'hB, 2);
        refuse_case(4'hF, 0);
        refuse_case(4'hA, 1);
        // R8 R9: empty replies
        clear_rx(); send(4'h9, 20'h00010, 3); finish_seq(1, 0);
        send(4'h8, 20'h00010, 3); finish_seq(1, 0);
        // R10: request while busy is ignored
        clear_rx(); rxb[0] = 8'h00; rxb[1] = 8'h01;
        send(4'h8, 20'h01234, 2);
        req_cmd = 4'h9; req_addr = 20'h0F0F0; req_size = 5'd7; req_valid = 1'b1;
        @(negedge clk); @(negedge clk);
        req_valid = 1'b0;
        finish_seq(1, 2);
        // R10: back-to-back request right after a response
        send(4'h9, 20'h00333, 1); finish_seq(0, 2);

        repeat (3) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R10 watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

endmodule